// File: doc/BRIEF.md
# Indexed Color Palette with Sequential Loader

This block holds a 256-entry color lookup table and translates 8-bit pixel indices into 24-bit RGB values. Software loads the table through a small two-register write window. One register sets the palette index where loading starts. The other register takes color bytes. Each byte goes to the next color channel of the current entry, cycling red, green, blue. After each blue byte the index moves to the next entry.

A color-map write can carry a single byte or a full 32-bit word. A word is split into four color bytes, starting with the most significant byte, and all four are stored in the same clock cycle. A separate pixel port takes one index per cycle and returns the matching RGB value one cycle later, together with a delayed valid flag. A one-cycle update pulse after every color-map write tells downstream logic that the palette has changed.

Top module: `clut_palette`

## Requirements
- R1: A write to offset 0x0 (the index register) loads bus_wdata[7:0] as the current palette index and sets the color phase to red.
- R2: A byte write (bus_wide = 0) to offset 0x4 (the color-map register) stores bus_wdata[7:0] into the channel of the current entry chosen by the phase. The phases follow the order red, green, blue.
- R3: When a blue byte is stored, the index advances by one modulo 256 (255 wraps to 0) and the phase returns to red.
- R4: A word write (bus_wide = 1) to offset 0x4 acts as four consecutive byte writes using bus_wdata[31:24], [23:16], [15:8] and [7:0] in that order. The phase and index advance once per byte, and all four bytes take effect in the same cycle.
- R5: bus_rdata always reads as zero.
- R6: When pix_valid_i is high in a cycle, pix_valid_o is high in the next cycle and pix_rgb_o = {red[p], green[p], blue[p]}. Red is in bits 23:16, green in 15:8 and blue in 7:0. pix_valid_o is low one cycle after pix_valid_i is low.
- R7: Reset clears every palette entry to zero, sets the index to 0 and the phase to red, and drives pix_valid_o, pix_rgb_o and pal_upd_o low.
- R8: pal_upd_o is high for exactly the one cycle after each color-map write. It stays low after index-register writes.
- R9: Writes to any offset other than 0x0 and 0x4 leave the index, the phase and the palette contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 5 | Byte offset in the register window |
| bus_wide | input | 1 | 1 = 32-bit write, 0 = single-byte write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (always zero) |
| pix_valid_i | input | 1 | Pixel index valid |
| pix_idx_i | input | 8 | Pixel index to look up |
| pix_valid_o | output | 1 | Lookup result valid |
| pix_rgb_o | output | 24 | Looked-up color {R,G,B} |
| pal_upd_o | output | 1 | One-cycle pulse after each color-map write |

## Verification
Timing of each result:
- A register write takes effect at the clock edge that samples it. A pixel lookup presented in the following cycle therefore already sees the new color.
- The lookup result and its valid flag appear one edge after the index is presented.
- pal_upd_o rises at the edge that samples the color-map write and falls at the next edge.

How the bench keeps to this timing:
- It drives every input one time unit after a rising edge and samples outputs one time unit after the next rising edge, so each result is read in exactly the cycle it is due.
- It compares results against a byte-level palette model that it updates itself.
- Directed index wraps and word writes starting at each phase are mixed with a seeded random sequence of writes. The sequence ends with a sweep over all 256 entries.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int CLUT_IDX_W  = 8;
    localparam int CLUT_CH_W   = 8;
    localparam int CLUT_LANES  = 4;
    localparam int CLUT_ADDR_W = 5;
    localparam logic [CLUT_ADDR_W-1:0] CLUT_OFS_INDEX = 5'h00;
    localparam logic [CLUT_ADDR_W-1:0] CLUT_OFS_CMAP  = 5'h04;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    function automatic phase_e phase_after(phase_e ph);
        case (ph)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W  = CLUT_IDX_W,
    parameter int CH_W   = CLUT_CH_W,
    parameter int LANES  = CLUT_LANES,
    parameter int ADDR_W = CLUT_ADDR_W,
    parameter logic [ADDR_W-1:0] OFS_INDEX = CLUT_OFS_INDEX,
    parameter logic [ADDR_W-1:0] OFS_CMAP  = CLUT_OFS_CMAP
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wide,
    input  logic [LANES*CH_W-1:0]   bus_wdata,
    output logic                    slot_en  [LANES],
    output logic [IDX_W-1:0]        slot_idx [LANES],
    output phase_e                  slot_ph  [LANES],
    output logic [CH_W-1:0]         slot_val [LANES],
    output logic [IDX_W-1:0]        cur_idx,
    output phase_e                  cur_phase,
    output logic                    upd_pulse
);

    localparam int WORD_W = LANES * CH_W;

    logic   idx_wr, cmap_wr;
    logic [IDX_W-1:0] idx_walk, idx_nxt;
    phase_e ph_walk, ph_nxt;

    assign idx_wr  = bus_wr && (bus_addr == OFS_INDEX);
    assign cmap_wr = bus_wr && (bus_addr == OFS_CMAP);

    // Walk the byte slots in order; each active slot consumes one phase step.
    always_comb begin
        idx_walk = cur_idx;
        ph_walk  = cur_phase;
        for (int k = 0; k < LANES; k++) begin
            slot_en[k]  = cmap_wr && (bus_wide || k == 0);
            slot_idx[k] = idx_walk;
            slot_ph[k]  = ph_walk;
            slot_val[k] = bus_wide ? bus_wdata[WORD_W-1-k*CH_W -: CH_W]
                                   : bus_wdata[CH_W-1:0];
            if (slot_en[k]) begin
                if (ph_walk == PH_BLU) begin
                    idx_walk = idx_walk + 1'b1;
                end
                ph_walk = phase_after(ph_walk);
            end
        end
        idx_nxt = cur_idx;
        ph_nxt  = cur_phase;
        if (idx_wr) begin
            idx_nxt = bus_wdata[IDX_W-1:0];
            ph_nxt  = PH_RED;
        end else if (cmap_wr) begin
            idx_nxt = idx_walk;
            ph_nxt  = ph_walk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx   <= '0;
            cur_phase <= PH_RED;
            upd_pulse <= 1'b0;
        end else begin
            cur_idx   <= idx_nxt;
            cur_phase <= ph_nxt;
            upd_pulse <= cmap_wr;
        end
    end

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int IDX_W = CLUT_IDX_W,
    parameter int CH_W  = CLUT_CH_W,
    parameter int LANES = CLUT_LANES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slot_en  [LANES],
    input  logic [IDX_W-1:0]   slot_idx [LANES],
    input  phase_e             slot_ph  [LANES],
    input  logic [CH_W-1:0]    slot_val [LANES],
    input  logic               pix_valid_i,
    input  logic [IDX_W-1:0]   pix_idx_i,
    output logic               pix_valid_o,
    output logic [3*CH_W-1:0]  pix_rgb_o
);

    localparam int DEPTH = 1 << IDX_W;

    logic [CH_W-1:0] red_q [DEPTH];
    logic [CH_W-1:0] grn_q [DEPTH];
    logic [CH_W-1:0] blu_q [DEPTH];

    // Within one word no two slots hit the same entry and channel.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                red_q[i] <= '0;
                grn_q[i] <= '0;
                blu_q[i] <= '0;
            end
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (slot_en[k]) begin
                    case (slot_ph[k])
                        PH_RED:  red_q[slot_idx[k]] <= slot_val[k];
                        PH_GRN:  grn_q[slot_idx[k]] <= slot_val[k];
                        default: blu_q[slot_idx[k]] <= slot_val[k];
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid_o <= 1'b0;
            pix_rgb_o   <= '0;
        end else begin
            pix_valid_o <= pix_valid_i;
            if (pix_valid_i) begin
                pix_rgb_o <= {red_q[pix_idx_i], grn_q[pix_idx_i], blu_q[pix_idx_i]};
            end
        end
    end

endmodule

// File: rtl/clut_palette.sv
module clut_palette
    import clut_pkg::*;
#(
    parameter int IDX_W  = CLUT_IDX_W,
    parameter int CH_W   = CLUT_CH_W,
    parameter int LANES  = CLUT_LANES,
    parameter int ADDR_W = CLUT_ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wide,
    input  logic [LANES*CH_W-1:0]  bus_wdata,
    output logic [LANES*CH_W-1:0]  bus_rdata,
    input  logic                   pix_valid_i,
    input  logic [IDX_W-1:0]       pix_idx_i,
    output logic                   pix_valid_o,
    output logic [3*CH_W-1:0]      pix_rgb_o,
    output logic                   pal_upd_o
);

    logic             slot_en  [LANES];
    logic [IDX_W-1:0] slot_idx [LANES];
    phase_e           slot_ph  [LANES];
    logic [CH_W-1:0]  slot_val [LANES];
    logic [IDX_W-1:0] cur_idx;
    phase_e           cur_phase;

    assign bus_rdata = '0;

    clut_seq #(
        .IDX_W(IDX_W), .CH_W(CH_W), .LANES(LANES), .ADDR_W(ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wide  (bus_wide),
        .bus_wdata (bus_wdata),
        .slot_en   (slot_en),
        .slot_idx  (slot_idx),
        .slot_ph   (slot_ph),
        .slot_val  (slot_val),
        .cur_idx   (cur_idx),
        .cur_phase (cur_phase),
        .upd_pulse (pal_upd_o)
    );

    clut_store #(
        .IDX_W(IDX_W), .CH_W(CH_W), .LANES(LANES)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .slot_en     (slot_en),
        .slot_idx    (slot_idx),
        .slot_ph     (slot_ph),
        .slot_val    (slot_val),
        .pix_valid_i (pix_valid_i),
        .pix_idx_i   (pix_idx_i),
        .pix_valid_o (pix_valid_o),
        .pix_rgb_o   (pix_rgb_o)
    );

endmodule

// File: rtl/clut_palette_chk.sv
module clut_palette_chk
    import clut_pkg::*;
#(
    parameter int IDX_W  = CLUT_IDX_W,
    parameter int CH_W   = CLUT_CH_W,
    parameter int LANES  = CLUT_LANES,
    parameter int ADDR_W = CLUT_ADDR_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wide,
    input logic [LANES*CH_W-1:0] bus_wdata,
    input logic                  pix_valid_i,
    input logic                  pix_valid_o,
    input logic [3*CH_W-1:0]     pix_rgb_o,
    input logic                  pal_upd_o,
    input logic [IDX_W-1:0]      cur_idx,
    input phase_e                cur_phase
);

    logic armed;
    always_ff @(posedge clk) begin
        armed <= !rst;
    end

    logic idx_wr, cmap_wr, other_wr;
    assign idx_wr   = bus_wr && (bus_addr == CLUT_OFS_INDEX);
    assign cmap_wr  = bus_wr && (bus_addr == CLUT_OFS_CMAP);
    assign other_wr = bus_wr && !idx_wr && !cmap_wr;

    p_index_load_r1: assert property (@(posedge clk) disable iff (rst)
        armed && $past(idx_wr) |->
            cur_phase == PH_RED && cur_idx == $past(bus_wdata[IDX_W-1:0]));

    p_blue_advance_r3: assert property (@(posedge clk) disable iff (rst)
        armed && $past(cmap_wr && !bus_wide && cur_phase == PH_BLU) |->
            cur_idx == $past(cur_idx) + 1'b1 && cur_phase == PH_RED);

    p_word_phase_r4: assert property (@(posedge clk) disable iff (rst)
        armed && $past(cmap_wr && bus_wide) |->
            cur_phase == phase_after($past(cur_phase)));

    p_valid_delay_r6: assert property (@(posedge clk) disable iff (rst)
        armed |-> pix_valid_o == $past(pix_valid_i));

    p_reset_out_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pix_valid_o && pix_rgb_o == '0 && !pal_upd_o);

    p_upd_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        armed |-> pal_upd_o == $past(cmap_wr));

    p_other_noop_r9: assert property (@(posedge clk) disable iff (rst)
        armed && $past(other_wr) |-> $stable(cur_idx) && $stable(cur_phase));

endmodule

bind clut_palette clut_palette_chk #(
    .IDX_W(IDX_W), .CH_W(CH_W), .LANES(LANES), .ADDR_W(ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wide    (bus_wide),
    .bus_wdata   (bus_wdata),
    .pix_valid_i (pix_valid_i),
    .pix_valid_o (pix_valid_o),
    .pix_rgb_o   (pix_rgb_o),
    .pal_upd_o   (pal_upd_o),
    .cur_idx     (cur_idx),
    .cur_phase   (cur_phase)
);

// File: tb/tb_clut_palette.sv
`timescale 1ns/1ps
module tb_clut_palette;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [4:0]  bus_addr;
    logic        bus_wide;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        pix_valid_i;
    logic [7:0]  pix_idx_i;
    logic        pix_valid_o;
    logic [23:0] pix_rgb_o;
    logic        pal_upd_o;

    always #5 clk = ~clk;

    clut_palette dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_valid_i(pix_valid_i), .pix_idx_i(pix_idx_i),
        .pix_valid_o(pix_valid_o), .pix_rgb_o(pix_rgb_o), .pal_upd_o(pal_upd_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_r [256];
    logic [7:0] m_g [256];
    logic [7:0] m_b [256];
    logic [7:0] m_idx;
    int         m_ph;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] m_rgb(logic [7:0] p);
        return {m_r[p], m_g[p], m_b[p]};
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 256; i++) begin
            m_r[i] = 8'h00; m_g[i] = 8'h00; m_b[i] = 8'h00;
        end
        m_idx = 8'h00;
        m_ph  = 0;
    endtask

    task automatic m_byte(logic [7:0] v);
        case (m_ph)
            0: m_r[m_idx] = v;
            1: m_g[m_idx] = v;
            default: m_b[m_idx] = v;
        endcase
        if (m_ph == 2) begin
            m_ph  = 0;
            m_idx = m_idx + 8'd1;
        end else begin
            m_ph = m_ph + 1;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wide = 1'b0;
        bus_wdata = '0; pix_valid_i = 1'b0; pix_idx_i = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        m_reset();
    endtask

    // Drive one bus write for a cycle; update the model; check the update pulse (R8).
    task automatic bus_write(logic [4:0] a, logic wide, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wide = wide; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
        if (a == 5'h00) begin
            m_idx = d[7:0]; m_ph = 0;
        end else if (a == 5'h04) begin
            if (wide) begin
                m_byte(d[31:24]); m_byte(d[23:16]); m_byte(d[15:8]); m_byte(d[7:0]);
            end else begin
                m_byte(d[7:0]);
            end
        end
        chk("R8 upd pulse", {31'b0, pal_upd_o}, {31'b0, (a == 5'h04)});
    endtask

    task automatic look(string req, logic [7:0] p);
        pix_valid_i = 1'b1; pix_idx_i = p;
        @(posedge clk);
        #1 pix_valid_i = 1'b0;
        chk("R6 valid", {31'b0, pix_valid_o}, 32'd1);
        chk(req, {8'h00, pix_rgb_o}, {8'h00, m_rgb(p)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R7: reset state
        chk("R7 valid low", {31'b0, pix_valid_o}, 32'd0);
        chk("R7 upd low", {31'b0, pal_upd_o}, 32'd0);
        chk("R7 rgb low", {8'h0, pix_rgb_o}, 32'd0);
        look("R7 entry0 zero", 8'd0);
        look("R7 entry255 zero", 8'd255);
        // R6: no valid in, no valid out
        @(posedge clk); #1;
        chk("R6 valid follows low", {31'b0, pix_valid_o}, 32'd0);
        chk("R8 pulse drops", {31'b0, pal_upd_o}, 32'd0);

        // R5: reads return zero at both offsets
        bus_addr = 5'h00; #1 chk("R5 rdata idx", bus_rdata, 32'd0);
        bus_addr = 5'h04; #1 chk("R5 rdata cmap", bus_rdata, 32'd0);

        // R1/R2/R3: byte writes
        bus_write(5'h00, 1'b0, 32'h0000_0005);
        bus_write(5'h04, 1'b0, 32'hFFFF_FF11);
        bus_write(5'h04, 1'b0, 32'h0000_0022);
        bus_write(5'h04, 1'b0, 32'h0000_0033);
        look("R2 entry5 rgb", 8'd5);
        bus_write(5'h04, 1'b0, 32'h0000_0044);
        look("R3 next entry red", 8'd6);
        // R1: index write mid-entry resets phase
        bus_write(5'h00, 1'b0, 32'h0000_0007);
        bus_write(5'h04, 1'b0, 32'h0000_0055);
        bus_write(5'h00, 1'b0, 32'h0000_0007);
        bus_write(5'h04, 1'b0, 32'h0000_0066);
        look("R1 phase back to red", 8'd7);
        // R3: wrap 255 -> 0
        bus_write(5'h00, 1'b0, 32'h0000_00FF);
        bus_write(5'h04, 1'b0, 32'h0000_00A1);
        bus_write(5'h04, 1'b0, 32'h0000_00A2);
        bus_write(5'h04, 1'b0, 32'h0000_00A3);
        bus_write(5'h04, 1'b0, 32'h0000_00B0);
        look("R3 entry255", 8'd255);
        look("R3 wrap to 0", 8'd0);
        // R4: word writes at each starting phase
        bus_write(5'h00, 1'b0, 32'h0000_000A);
        bus_write(5'h04, 1'b1, 32'hAABB_CCDD);
        look("R4 word entry10", 8'd10);
        bus_write(5'h04, 1'b1, 32'h1122_3344);
        look("R4 word from green", 8'd11);
        bus_write(5'h04, 1'b1, 32'h5566_7788);
        look("R4 word from blue e12", 8'd12);
        look("R4 word from blue e13", 8'd13);
        // R9: other offsets ignored
        bus_write(5'h08, 1'b1, 32'hDEAD_BEEF);
        bus_write(5'h10, 1'b0, 32'h0000_0001);
        bus_write(5'h04, 1'b0, 32'h0000_00C7);
        look("R9 sequence unchanged e13", 8'd13);
        look("R9 entry1 untouched", 8'd1);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel == 0)      bus_write(5'h00, 1'b0, $urandom());
            else if (sel == 1) bus_write(5'h0C, $urandom_range(0, 1) == 1, $urandom());
            else if (sel < 6)  bus_write(5'h04, 1'b0, $urandom());
            else if (sel < 9)  bus_write(5'h04, 1'b1, $urandom());
            else               look("R2 R4 random", 8'($urandom_range(0, 255)));
        end
        for (int p = 0; p < 256; p++) look("R6 sweep", 8'(p));

        // R7: reset mid-run clears palette and phase
        do_reset();
        look("R7 cleared e12", 8'd12);
        bus_write(5'h04, 1'b0, 32'h0000_0099);
        look("R7 phase red idx0", 8'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule